// File: doc/BRIEF.md
# Multiplexed External Memory Bus Controller

This block carries single-beat read and write requests from an on-chip requester to either on-chip memory or an external SRAM. Requests arrive on a 16-bit address, 8-bit data valid/ready interface. Each address is compared with a programmable internal-memory boundary. Addresses above the boundary are external. Addresses at or below it are served by an internal memory port.

The external bus is multiplexed. One 8-bit port carries the low address byte during an address phase and then carries data. The high address byte has its own 8-bit port. An address-latch-enable strobe lets an external transparent latch capture the low byte on its falling edge. Active-low read and write strobes then frame the transfer, and a configurable wait-state count stretches the strobe phase. While the bus is enabled, internal accesses run the same pin sequence with the read and write strobes held inactive.

When the bus is disabled, the pins return to normal port control. Internal accesses finish quickly through the internal memory port. External addresses complete with a fixed filler value and touch no memory.

Top module: `xbus_ctrl`

## Requirements
- R1: After reset, req_ready is 0, ale_o is 0, rd_n_o and wr_n_o are 1, and ad_oe_o is 0.
- R2: An enabled access puts the low address byte on ad_o (ad_oe_o=1) and the high byte on ah_o for exactly one clock with ale_o=1, the clock after the request is accepted; ale_o is then 0 for the rest of the access.
- R3: An enabled external write holds ad_oe_o=1 with ad_o equal to the write data from the clock after ale_o falls through the clock in which req_ready is 1, and drives wr_n_o low for 1+cfg_wait clocks.
- R4: An access is external when req_addr > cfg_bound (unsigned) and internal when req_addr <= cfg_bound.
- R5: An enabled internal access keeps rd_n_o and wr_n_o at 1 throughout and reads or writes through the internal memory port.
- R6: With cfg_en=1, req_ready rises in the (4+cfg_wait)-th clock after the accepting edge, counting the cycle after that edge as 1.
- R7: rd_n_o and wr_n_o are never both 0, and neither is 0 while ale_o is 1.
- R8: With cfg_en=0, pins_own_o is 0, ale_o, ad_oe_o and the strobes stay inactive, and req_ready rises in the 2nd clock after acceptance.
- R9: With cfg_en=0, an external read returns 8'hFF, and an external write changes neither external memory nor any internal location (no aliasing).
- R10: req_ready is a one-clock pulse, and req_rdata carries the read data in that clock.
- R11: An enabled external read keeps ad_oe_o=0 from the clock after ale_o falls, drives rd_n_o low for 1+cfg_wait clocks, and returns the value on ad_i sampled at the edge where rd_n_o rises.
- R12: A request held valid across the ready clock is accepted on the edge after the ready clock, so its own ready comes 5+cfg_wait clocks after the previous one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_en | input | 1 | External bus enable |
| cfg_wait | input | 2 | Wait states added to the strobe phase |
| cfg_bound | input | 16 | Highest internal address |
| req_valid | input | 1 | Request valid, held until req_ready |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 16 | Request address |
| req_wdata | input | 8 | Write data |
| req_ready | output | 1 | One-clock completion pulse |
| req_rdata | output | 8 | Read data, valid with req_ready |
| imem_addr | output | 16 | Internal memory address |
| imem_wdata | output | 8 | Internal memory write data |
| imem_we | output | 1 | Internal memory write enable |
| imem_rdata | input | 8 | Internal memory read data |
| ad_o | output | 8 | Multiplexed address/data output value |
| ad_oe_o | output | 1 | Multiplexed port output enable |
| ad_i | input | 8 | Multiplexed port input value |
| ah_o | output | 8 | High address byte |
| ale_o | output | 1 | Address latch enable |
| rd_n_o | output | 1 | Read strobe, active low |
| wr_n_o | output | 1 | Write strobe, active low |
| pins_own_o | output | 1 | Bus pins overridden by this block |

## Verification
Two events can land on one edge. In the clock where an access reports req_ready, the requester may already present its next request. Separately, the edge that raises rd_n_o is also the edge that captures ad_i. The bench keeps req_valid high through a ready pulse with new request fields. It then checks that the second access is not taken during the ready clock, that its ready comes exactly 5+cfg_wait clocks later, and that each read returns the SRAM model's value as driven while the strobe was still low.

// File: rtl/xbus_pkg.sv
package xbus_pkg;
    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_ADDR  = 3'd1,
        ST_DATA  = 3'd2,
        ST_STRB  = 3'd3,
        ST_QUICK = 3'd4,
        ST_DONE  = 3'd5
    } xbus_state_e;
endpackage

// File: rtl/xbus_addr_class.sv
module xbus_addr_class #(
    parameter int AW = 16
) (
    input  logic [AW-1:0] addr,
    input  logic [AW-1:0] bound,
    output logic          is_ext
);
    // Unsigned compare: the boundary address itself is still internal.
    always_comb is_ext = (addr > bound);
endmodule

// File: rtl/xbus_pin_drive.sv
module xbus_pin_drive
    import xbus_pkg::*;
#(
    parameter int AW = 16,
    parameter int DW = 8
) (
    input  xbus_state_e   st,
    input  logic          bus,
    input  logic          ext,
    input  logic          wr,
    input  logic          cfg_en,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] ad_o,
    output logic          ad_oe_o,
    output logic [AW-DW-1:0] ah_o,
    output logic          ale_o,
    output logic          rd_n_o,
    output logic          wr_n_o,
    output logic          pins_own_o
);
    logic on_bus;
    logic data_ph;

    always_comb begin
        on_bus     = bus && (st inside {ST_ADDR, ST_DATA, ST_STRB, ST_DONE});
        data_ph    = st inside {ST_DATA, ST_STRB, ST_DONE};
        ale_o      = on_bus && (st == ST_ADDR);
        ad_oe_o    = on_bus && ((st == ST_ADDR) || (wr && data_ph));
        ad_o       = (st == ST_ADDR) ? addr[DW-1:0] : wdata;
        ah_o       = on_bus ? addr[AW-1:DW] : '0;
        rd_n_o     = !(on_bus && ext && !wr && (st == ST_STRB));
        wr_n_o     = !(on_bus && ext && wr && (st == ST_STRB));
        pins_own_o = cfg_en || on_bus;
    end
endmodule

// File: rtl/xbus_ctrl.sv
module xbus_ctrl
    import xbus_pkg::*;
#(
    parameter int              AW       = 16,
    parameter int              DW       = 8,
    parameter int              WSW      = 2,
    parameter logic [DW-1:0]   UNMAPPED = 8'hFF
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_en,
    input  logic [WSW-1:0]   cfg_wait,
    input  logic [AW-1:0]    cfg_bound,
    input  logic             req_valid,
    input  logic             req_write,
    input  logic [AW-1:0]    req_addr,
    input  logic [DW-1:0]    req_wdata,
    output logic             req_ready,
    output logic [DW-1:0]    req_rdata,
    output logic [AW-1:0]    imem_addr,
    output logic [DW-1:0]    imem_wdata,
    output logic             imem_we,
    input  logic [DW-1:0]    imem_rdata,
    output logic [DW-1:0]    ad_o,
    output logic             ad_oe_o,
    input  logic [DW-1:0]    ad_i,
    output logic [AW-DW-1:0] ah_o,
    output logic             ale_o,
    output logic             rd_n_o,
    output logic             wr_n_o,
    output logic             pins_own_o
);
    localparam int HW = AW - DW;

    typedef struct packed {
        xbus_state_e    st;
        logic [WSW-1:0] cnt;
        logic [AW-1:0]  addr;
        logic [DW-1:0]  wdata;
        logic           wr;
        logic           ext;
        logic           bus;
        logic [DW-1:0]  rdata;
    } regs_t;

    regs_t r_d, r_q;
    logic  req_ext;
    logic  last_strb;

    xbus_addr_class #(.AW(AW)) u_class (
        .addr   (req_addr),
        .bound  (cfg_bound),
        .is_ext (req_ext)
    );

    always_comb begin
        r_d       = r_q;
        last_strb = (r_q.st == ST_STRB) && (r_q.cnt == '0);
        unique case (r_q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    r_d.addr  = req_addr;
                    r_d.wdata = req_wdata;
                    r_d.wr    = req_write;
                    r_d.ext   = req_ext;
                    r_d.bus   = cfg_en;
                    r_d.cnt   = cfg_wait;
                    r_d.st    = cfg_en ? ST_ADDR : ST_QUICK;
                end
            end
            ST_ADDR: r_d.st = ST_DATA;
            ST_DATA: r_d.st = ST_STRB;
            ST_STRB: begin
                if (r_q.cnt == '0) begin
                    r_d.st    = ST_DONE;
                    r_d.rdata = r_q.ext ? ad_i : imem_rdata;
                end else begin
                    r_d.cnt = r_q.cnt - 1'b1;
                end
            end
            ST_QUICK: begin
                r_d.st    = ST_DONE;
                r_d.rdata = r_q.ext ? UNMAPPED : imem_rdata;
            end
            ST_DONE: r_d.st = ST_IDLE;
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{st: ST_IDLE, default: '0};
        end else begin
            r_q <= r_d;
        end
    end

    always_comb begin
        req_ready  = (r_q.st == ST_DONE);
        req_rdata  = r_q.rdata;
        imem_addr  = r_q.addr;
        imem_wdata = r_q.wdata;
        imem_we    = !r_q.ext && r_q.wr && (last_strb || (r_q.st == ST_QUICK));
    end

    xbus_pin_drive #(.AW(AW), .DW(DW)) u_pins (
        .st         (r_q.st),
        .bus        (r_q.bus),
        .ext        (r_q.ext),
        .wr         (r_q.wr),
        .cfg_en     (cfg_en),
        .addr       (r_q.addr),
        .wdata      (r_q.wdata),
        .ad_o       (ad_o),
        .ad_oe_o    (ad_oe_o),
        .ah_o       (ah_o),
        .ale_o      (ale_o),
        .rd_n_o     (rd_n_o),
        .wr_n_o     (wr_n_o),
        .pins_own_o (pins_own_o)
    );

    logic [HW-1:0] unused_hw;
    assign unused_hw = '0;
endmodule

// File: rtl/xbus_ctrl_chk.sv
module xbus_ctrl_chk #(
    parameter int AW = 16,
    parameter int DW = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic [AW-1:0]    cfg_bound,
    input logic             req_ready,
    input logic [DW-1:0]    ad_o,
    input logic             ad_oe_o,
    input logic [AW-DW-1:0] ah_o,
    input logic             ale_o,
    input logic             rd_n_o,
    input logic             wr_n_o,
    input logic             pins_own_o
);
    a_r7_strobes_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(!rd_n_o && !wr_n_o));

    a_r7_no_strobe_in_ale: assert property (@(posedge clk) disable iff (!rst_n)
        ale_o |-> (rd_n_o && wr_n_o));

    a_r2_ale_single: assert property (@(posedge clk) disable iff (!rst_n)
        ale_o |=> !ale_o);

    a_r10_ready_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |=> !req_ready);

    a_r3_data_after_wr: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wr_n_o) |-> ad_oe_o);

    a_r5_internal_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (ale_o && ({ah_o, ad_o} <= cfg_bound)) |=> ##1 (rd_n_o && wr_n_o));

    a_r8_released_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !pins_own_o |-> (!ale_o && rd_n_o && wr_n_o && !ad_oe_o));
endmodule

bind xbus_ctrl xbus_ctrl_chk #(.AW(AW), .DW(DW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_bound  (cfg_bound),
    .req_ready  (req_ready),
    .ad_o       (ad_o),
    .ad_oe_o    (ad_oe_o),
    .ah_o       (ah_o),
    .ale_o      (ale_o),
    .rd_n_o     (rd_n_o),
    .wr_n_o     (wr_n_o),
    .pins_own_o (pins_own_o)
);

// File: tb/xbus_ctrl_bench.sv
module xbus_ctrl_bench;
    localparam logic [15:0] BOUND = 16'h025F;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_en = 1'b0;
    logic [1:0]  cfg_wait = 2'd0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [15:0] req_addr = '0;
    logic [7:0]  req_wdata = '0;
    logic        req_ready;
    logic [7:0]  req_rdata;
    logic [15:0] imem_addr;
    logic [7:0]  imem_wdata;
    logic        imem_we;
    logic [7:0]  imem_rdata;
    logic [7:0]  ad_o;
    logic        ad_oe_o;
    logic [7:0]  ad_i;
    logic [7:0]  ah_o;
    logic        ale_o, rd_n_o, wr_n_o, pins_own_o;

    int total = 0;
    int bad = 0;
    int r7_viol = 0;

    always #10 clk = ~clk;

    xbus_ctrl u_xbus_ctrl (
        .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en), .cfg_wait(cfg_wait),
        .cfg_bound(BOUND), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_ready(req_ready),
        .req_rdata(req_rdata), .imem_addr(imem_addr), .imem_wdata(imem_wdata),
        .imem_we(imem_we), .imem_rdata(imem_rdata), .ad_o(ad_o),
        .ad_oe_o(ad_oe_o), .ad_i(ad_i), .ah_o(ah_o), .ale_o(ale_o),
        .rd_n_o(rd_n_o), .wr_n_o(wr_n_o), .pins_own_o(pins_own_o)
    );

    // Memory models: external latch + SRAM, internal memory
    logic [7:0] ext_mem [1024];
    logic [7:0] int_mem [1024];
    logic [7:0] ref_ext [1024];
    logic [7:0] ref_int [1024];
    logic [7:0] lat;

    always_latch if (ale_o) lat <= ad_o;
    assign ad_i       = !rd_n_o ? ext_mem[{ah_o[1:0], lat}] : 8'h00;
    assign imem_rdata = int_mem[imem_addr[9:0]];

    always @(posedge clk) begin
        if (!wr_n_o) ext_mem[{ah_o[1:0], lat}] <= ad_o;
        if (imem_we) int_mem[imem_addr[9:0]] <= imem_wdata;
    end

    always @(negedge clk) begin
        if (rst_n && ((!rd_n_o && !wr_n_o) || (ale_o && (!rd_n_o || !wr_n_o))))
            r7_viol++;
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // {en, wait, write, addr, wdata}
    localparam logic [27:0] VEC [13] = '{
        {1'b1, 2'd0, 1'b1, 16'h8123, 8'h5A},
        {1'b1, 2'd0, 1'b0, 16'h8123, 8'h00},
        {1'b1, 2'd3, 1'b1, 16'h0260, 8'hC3},
        {1'b1, 2'd3, 1'b0, 16'h0260, 8'h00},
        {1'b1, 2'd1, 1'b1, 16'h025F, 8'h77},
        {1'b1, 2'd1, 1'b0, 16'h025F, 8'h00},
        {1'b0, 2'd0, 1'b0, 16'h025F, 8'h00},
        {1'b0, 2'd0, 1'b1, 16'h8123, 8'h11},
        {1'b1, 2'd2, 1'b0, 16'h8123, 8'h00},
        {1'b0, 2'd0, 1'b0, 16'h8123, 8'h00},
        {1'b0, 2'd0, 1'b1, 16'h0010, 8'h3C},
        {1'b1, 2'd2, 1'b0, 16'h0010, 8'h00},
        {1'b1, 2'd0, 1'b0, 16'h0123, 8'h00}
    };

    task automatic run_txn(input logic en, input logic [1:0] ws, input logic wr,
                           input logic [15:0] a, input logic [7:0] wd);
        int lat_k = 0, ale_n = 0, rd_cnt = 0, wr_cnt = 0, oe_n = 0;
        bit addr_ok = 1, data_ok = 1, own_ok = 1;
        logic [7:0] got = '0;
        logic [7:0] exp;
        bit ext = (a > BOUND);
        cfg_en = en; cfg_wait = ws; req_write = wr; req_addr = a; req_wdata = wd;
        req_valid = 1'b1;
        for (int k = 1; k <= 20; k++) begin
            @(posedge clk); @(negedge clk);
            if (pins_own_o !== en) own_ok = 0;
            if (ad_oe_o) oe_n++;
            if (ale_o) begin
                ale_n++;
                if (k != 1 || ad_o !== a[7:0] || ah_o !== a[15:8] || !ad_oe_o) addr_ok = 0;
            end
            if (!rd_n_o) rd_cnt++;
            if (!wr_n_o) wr_cnt++;
            if (en && wr && k >= 2 && (!ad_oe_o || ad_o !== wd)) data_ok = 0;
            if (en && !wr && k >= 2 && ad_oe_o) data_ok = 0;
            if (req_ready) begin lat_k = k; got = req_rdata; break; end
        end
        req_valid = 1'b0;
        @(posedge clk); @(negedge clk);
        chk(!req_ready, "R10 ready pulse", req_ready, 0);

        if (en) begin
            chk(lat_k == 4 + ws, "R6 latency", lat_k, 4 + ws);
            chk(ale_n == 1 && addr_ok, "R2 address phase", ale_n, 1);
            chk(own_ok, "R8 own flag enabled", 0, 1);
            if (ext && wr) begin
                chk(wr_cnt == 1 + ws && rd_cnt == 0, "R3 WR width", wr_cnt, 1 + ws);
                chk(data_ok, "R3 write data drive", 0, 1);
            end else if (ext) begin
                chk(rd_cnt == 1 + ws && wr_cnt == 0, "R11 RD width", rd_cnt, 1 + ws);
                chk(data_ok, "R11 port released", 0, 1);
            end else begin
                chk(rd_cnt == 0 && wr_cnt == 0, "R5 strobes quiet R4", rd_cnt + wr_cnt, 0);
            end
        end else begin
            chk(lat_k == 2, "R8 latency", lat_k, 2);
            chk(ale_n == 0 && rd_cnt == 0 && wr_cnt == 0 && oe_n == 0 && own_ok,
                "R8 pins released", ale_n + rd_cnt + wr_cnt + oe_n, 0);
        end

        if (wr) begin
            if (ext && en) ref_ext[a[9:0]] = wd;
            else if (!ext) ref_int[a[9:0]] = wd;
        end else begin
            if (ext) exp = en ? ref_ext[a[9:0]] : 8'hFF;
            else     exp = ref_int[a[9:0]];
            chk(got === exp, ext ? (en ? "R11 ext read" : "R9 unmapped read")
                                 : "R5 R9 R4 internal read", got, exp);
        end
    endtask

    initial begin
        for (int i = 0; i < 1024; i++) begin
            ext_mem[i] = 8'h00; int_mem[i] = 8'h00;
            ref_ext[i] = 8'h00; ref_int[i] = 8'h00;
        end
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(!req_ready && !ale_o && rd_n_o && wr_n_o && !ad_oe_o, "R1 reset outputs",
            {req_ready, ale_o, rd_n_o, wr_n_o, ad_oe_o}, 5'b00110);
        chk(!pins_own_o, "R8 released after reset", pins_own_o, 0);

        for (int v = 0; v < 13; v++)
            run_txn(VEC[v][27], VEC[v][26:25], VEC[v][24], VEC[v][23:8], VEC[v][7:0]);

        // R12 back-to-back: next request presented during the ready clock
        begin
            int k1 = 0, k2 = 0;
            cfg_en = 1'b1; cfg_wait = 2'd1; req_write = 1'b0; req_addr = 16'h8123;
            req_valid = 1'b1;
            for (int k = 1; k <= 20; k++) begin
                @(posedge clk); @(negedge clk);
                if (req_ready) begin k1 = k; break; end
            end
            chk(req_rdata === ref_ext[10'h123], "R12 first read", req_rdata, ref_ext[10'h123]);
            req_addr = 16'h0260;
            for (int k = 1; k <= 20; k++) begin
                @(posedge clk); @(negedge clk);
                if (req_ready) begin k2 = k; break; end
            end
            req_valid = 1'b0;
            chk(k1 == 5 && k2 == 6, "R12 back-to-back spacing", k2, 6);
            chk(req_rdata === ref_ext[10'h260], "R12 second read", req_rdata, ref_ext[10'h260]);
            @(posedge clk); @(negedge clk);
        end

        chk(r7_viol == 0, "R7 strobe exclusion", r7_viol, 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule